// File: doc/BRIEF.md
# Serial Byte Memory with Layered Write Protection

This block is the slave side of a four-wire serial bus in front of a small byte memory. The memory has a 13-bit address space. Each transaction is framed by the active-low select. The first byte is a command. Depending on the command, address and data bytes follow. Commands set or clear a write-enable latch, read or write a status byte that holds two block-protect bits and a protect-enable flag, and read or write the memory. Reads and writes stream over consecutive bytes, and the address advances after each byte.

A write is allowed only in layers. First, the write-enable latch must be set by its own command. For the array, the block-protect bits then decide which upper fraction of the address space refuses writes. For the status byte, the active-low write-protect pin must also be high. The write-protect pin never guards the array. A write always finishes at bus speed, so there is no busy flag.

The bus pins are sampled with the block's own clock, which must run well above the serial clock. The stored array holds 2^STORE_AW bytes. Address bits above that width alias onto the same cells, while the protect decision always uses the full 13-bit address.

Top module: `spi_wp_ctrl`

## Requirements
- R1: The status byte reads as bit 7 protect-enable flag, bit 3 and bit 2 the block-protect pair (high, low), bit 1 the write-enable latch, and bits 6 to 4 and bit 0 always 0, whatever value was written.
- R2: After reset the status byte reads 0x00, and the serial output is 0 while the select is high.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it. A status write never sets the latch from its data.
- R4: A status write (0x01 followed by one data byte) changes the protect-enable flag and the block-protect pair only if the write-enable latch is set.
- R5: A low write-protect pin rejects a status write. The pin has no effect on memory-array writes.
- R6: A write command (0x01 or 0x02) issued while the latch is set clears the latch when the select rises, whether or not any byte was accepted.
- R7: Status read (0x05) returns the status byte in the byte after the command. Any further bytes of that transaction read 0x00.
- R8: Memory read (0x03) takes a high then a low address byte, ignores the top 3 bits of the high byte, and returns data from consecutive addresses, wrapping from 0x1FFF to 0x0000. Cell index is the address modulo 2^STORE_AW.
- R9: Memory write (0x02) takes the same two address bytes, then stores each data byte at a consecutive address, with the same wrap. Bytes are stored only while the latch is set.
- R10: Block-protect pair 00 protects nothing, 01 protects 0x1800 to 0x1FFF, 10 protects 0x1000 to 0x1FFF, and 11 protects the whole space. A data byte aimed at a protected address is dropped, and the address still advances.
- R11: A rise of the select in the middle of a byte discards that partial byte, so a partial data byte is never stored.
- R12: Bus mode 0, MSB first. Input bits are taken on the rising serial clock edge. Output bits change after the falling edge, and the first bit of a reply byte is valid before that byte's first rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select that frames a transaction |
| sck | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low write-protect pin for the status byte |
| miso | output | 1 | Serial data out of the block |

## Verification
Two things happen in the same clock cycle when a write data byte completes: the protect decision for the current address, and the address increment. The protect decision must use the address before it advances. Bursts that start just below a protect boundary (0x17FE with pair 01) and at the top of the space (0x1FFF with pair 10, wrapping to 0x0000) make the last allowed and the first refused byte, or the refused and the wrapped allowed byte, meet in adjacent byte slots. Reading the cells back, including the aliases of the refused addresses, shows whether each byte was stored or dropped against a bench model.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;

    localparam int BYTE_W = 8;

    // command codes
    localparam logic [BYTE_W-1:0] OP_WEN  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WDIS = 8'h04;
    localparam logic [BYTE_W-1:0] OP_SRD  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_SWR  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_MRD  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_MWR  = 8'h02;

    // status byte bit positions
    localparam int SR_WPEN  = 7;
    localparam int SR_BP_HI = 3;
    localparam int SR_BP_LO = 2;
    localparam int SR_WEL   = 1;

    typedef enum logic [2:0] {
        PH_OPC = 3'd0,   // waiting for command byte
        PH_AHI = 3'd1,   // high address byte
        PH_ALO = 3'd2,   // low address byte
        PH_MRD = 3'd3,   // memory read stream
        PH_MWR = 3'd4,   // memory write stream
        PH_SRD = 3'd5,   // status byte being returned
        PH_SWR = 3'd6,   // status data byte expected
        PH_IGN = 3'd7    // rest of transaction ignored
    } phase_e;

    function automatic logic [BYTE_W-1:0] pack_status(
        input logic       wpen,
        input logic [1:0] bp,
        input logic       wel
    );
        logic [BYTE_W-1:0] s;
        s           = '0;
        s[SR_WPEN]  = wpen;
        s[SR_BP_HI] = bp[1];
        s[SR_BP_LO] = bp[0];
        s[SR_WEL]   = wel;
        return s;
    endfunction

endpackage

// File: rtl/spi_wp_sync.sv
// Brings the asynchronous bus pins into the block clock domain and
// derives edge strobes for the serial clock and the select.
module spi_wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic wp_n_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic wp_n_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_rise_o
);

    localparam int NSIG = 4;
    // order {wp_n, mosi, sck, cs_n}
    localparam logic [NSIG-1:0] IDLE = 4'b1001;

    logic [STAGES-1:0][NSIG-1:0] pipe_q, pipe_d;
    logic [1:0]                  last_q, last_d;
    logic [NSIG-1:0]             raw, cur;

    always_comb begin
        raw    = {wp_n_i, mosi_i, sck_i, cs_n_i};
        pipe_d = {pipe_q[STAGES-2:0], raw};
        cur    = pipe_q[STAGES-1];
        last_d = cur[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{IDLE}};
            last_q <= IDLE[1:0];
        end else begin
            pipe_q <= pipe_d;
            last_q <= last_d;
        end
    end

    assign cs_n_o     = cur[0];
    assign mosi_o     = cur[2];
    assign wp_n_o     = cur[3];
    assign sck_rise_o = cur[1] & ~last_q[1];
    assign sck_fall_o = ~cur[1] & last_q[1];
    assign cs_rise_o  = cur[0] & ~last_q[0];

endmodule

// File: rtl/spi_wp_guard.sv
// Decides whether a full-width address lies in the region closed by
// the block-protect pair.
module spi_wp_guard #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);

    always_comb begin
        unique case (bp)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = &addr[ADDR_W-1 -: 2];
            2'b10:   blocked = addr[ADDR_W-1];
            default: blocked = 1'b1;
        endcase
    end

endmodule

// File: rtl/spi_wp_store.sv
// Byte storage: one write port, one combinational read port.
module spi_wp_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= '0;
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl #(
    parameter int ADDR_W      = 13,
    parameter int STORE_AW    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);

    import spi_wp_pkg::*;

    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  rx;
        logic [BYTE_W-1:0]  tx;
        logic               dout;
        logic [ADDR_W-1:0]  addr;
        logic               rd_mode;
        logic               wel;
        logic               wpen;
        logic [1:0]         bp;
        logic               wr_pend;
    } ctl_t;

    ctl_t q, d;

    logic               cs_n_s, mosi_s, wp_n_s;
    logic               sck_rise, sck_fall, cs_rise;
    logic               blocked;
    logic               mem_we;
    logic [BYTE_W-1:0]  mem_rdata;
    logic [BYTE_W-1:0]  byte_in;
    logic               byte_done;
    logic [BYTE_W-1:0]  load_v;

    spi_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sck_i      (sck),
        .mosi_i     (mosi),
        .wp_n_i     (wp_n),
        .cs_n_o     (cs_n_s),
        .mosi_o     (mosi_s),
        .wp_n_o     (wp_n_s),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_rise_o  (cs_rise)
    );

    spi_wp_guard #(.ADDR_W(ADDR_W)) u_guard (
        .bp      (q.bp),
        .addr    (q.addr),
        .blocked (blocked)
    );

    spi_wp_store #(.AW(STORE_AW), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (q.addr[STORE_AW-1:0]),
        .wdata (byte_in),
        .raddr (q.addr[STORE_AW-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        byte_in   = {q.rx[BYTE_W-2:0], mosi_s};
        byte_done = sck_rise && !cs_n_s && (q.cnt == LAST_BIT);
        load_v    = '0;

        if (cs_rise) begin
            // end of transaction: drop partial byte, retire write
            d.ph      = PH_OPC;
            d.cnt     = '0;
            d.rx      = '0;
            d.tx      = '0;
            d.dout    = 1'b0;
            d.rd_mode = 1'b0;
            d.wr_pend = 1'b0;
            if (q.wr_pend) begin
                d.wel = 1'b0;
            end
        end else if (!cs_n_s) begin
            if (sck_rise) begin
                d.rx  = byte_in;
                d.cnt = q.cnt + 1'b1;
                if (byte_done) begin
                    unique case (q.ph)
                        PH_OPC: begin
                            d.ph = PH_IGN;
                            unique case (byte_in)
                                OP_WEN:  d.wel = 1'b1;
                                OP_WDIS: d.wel = 1'b0;
                                OP_SRD:  d.ph  = PH_SRD;
                                OP_SWR: begin
                                    d.ph      = PH_SWR;
                                    d.wr_pend = q.wel;
                                end
                                OP_MRD: begin
                                    d.ph      = PH_AHI;
                                    d.rd_mode = 1'b1;
                                end
                                OP_MWR: begin
                                    d.ph      = PH_AHI;
                                    d.rd_mode = 1'b0;
                                    d.wr_pend = q.wel;
                                end
                                default: d.ph = PH_IGN;
                            endcase
                        end
                        PH_AHI: begin
                            d.addr[ADDR_W-1:BYTE_W] = byte_in[HI_W-1:0];
                            d.ph = PH_ALO;
                        end
                        PH_ALO: begin
                            d.addr[BYTE_W-1:0] = byte_in;
                            d.ph = q.rd_mode ? PH_MRD : PH_MWR;
                        end
                        PH_MRD: begin
                            d.addr = q.addr + 1'b1;
                        end
                        PH_MWR: begin
                            // protect check uses the address before increment
                            mem_we = q.wel && !blocked;
                            d.addr = q.addr + 1'b1;
                        end
                        PH_SRD: begin
                            d.ph = PH_IGN;
                        end
                        PH_SWR: begin
                            if (q.wel && wp_n_s) begin
                                d.wpen = byte_in[SR_WPEN];
                                d.bp   = {byte_in[SR_BP_HI], byte_in[SR_BP_LO]};
                            end
                            d.ph = PH_IGN;
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall) begin
                if (q.cnt == '0) begin
                    // byte boundary: fetch the next reply byte
                    unique case (q.ph)
                        PH_SRD:  load_v = pack_status(q.wpen, q.bp, q.wel);
                        PH_MRD:  load_v = mem_rdata;
                        default: load_v = '0;
                    endcase
                    d.dout = load_v[BYTE_W-1];
                    d.tx   = {load_v[BYTE_W-2:0], 1'b0};
                end else begin
                    d.dout = q.tx[BYTE_W-1];
                    d.tx   = {q.tx[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso = q.dout;

endmodule

// File: rtl/spi_wp_chk.sv
module spi_wp_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_s,
    input logic              cs_rise,
    input logic              wp_n_s,
    input logic              wel,
    input logic              wpen,
    input logic [1:0]        bp,
    input logic              wr_pend,
    input logic              mem_we,
    input logic [ADDR_W-1:0] addr,
    input logic              miso
);

    localparam logic [ADDR_W-1:0] HALF_LO = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QTR_LO  = ADDR_W'(3) << (ADDR_W - 2);

    logic ref_closed;
    always_comb begin
        ref_closed = (bp == 2'b11)
                  || (bp == 2'b10 && addr >= HALF_LO)
                  || (bp == 2'b01 && addr >= QTR_LO);
    end

    // R2: output quiet while deselected
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !miso);

    // R3: the latch only sets inside a transaction
    p_wel_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(!cs_n_s));

    // R4: protect fields change only with the latch set
    p_sr_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bp) || !$stable(wpen)) |-> $past(wel));

    // R5: low pin freezes the protect fields
    p_sr_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_s |=> ($stable(bp) && $stable(wpen)));

    // R6: a pending write retires the latch at deselect
    p_wel_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && wr_pend) |=> !wel);

    // R10: never store into a closed region
    p_no_closed_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ref_closed);

    // R9: no store without the latch
    p_store_needs_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

endmodule

bind spi_wp_ctrl spi_wp_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (cs_n_s),
    .cs_rise (cs_rise),
    .wp_n_s  (wp_n_s),
    .wel     (q.wel),
    .wpen    (q.wpen),
    .bp      (q.bp),
    .wr_pend (q.wr_pend),
    .mem_we  (mem_we),
    .addr    (q.addr),
    .miso    (miso)
);

// File: tb/spi_wp_ctrl_bench.sv
`timescale 1ns/1ps
module spi_wp_ctrl_bench;

    localparam int HALF = 8;    // block clocks per serial half period
    localparam int SAW  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    logic miso;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] tbuf [16];
    logic [7:0] rbuf [16];
    logic [7:0] wdat [16];
    logic [7:0] mdl  [1 << SAW];
    logic       m_wel = 1'b0;
    logic       m_wpen = 1'b0;
    logic [1:0] m_bp = 2'b00;

    always #2 clk = ~clk;

    spi_wp_ctrl u_spi_wp_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .mosi  (mosi),
        .wp_n  (wp_n),
        .miso  (miso)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_stat();
        return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    function automatic logic m_closed(input logic [12:0] a);
        case (m_bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 13'h1800;
            2'b10:   return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    // full bytes from tbuf, then optional partial bits of tbuf[nbytes]
    task automatic xfer(input int nbytes, input int tail);
        cs_n = 1'b0;
        tick(HALF);
        for (int b = 0; b <= nbytes; b++) begin
            logic [7:0] r;
            int nb;
            r  = '0;
            nb = (b < nbytes) ? 8 : tail;
            for (int i = 7; i > 7 - nb; i--) begin
                mosi = tbuf[b][i];
                tick(HALF);
                r[i] = miso;
                sck = 1'b1;
                tick(HALF);
                sck = 1'b0;
            end
            rbuf[b] = r;
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF + 4);
    endtask

    task automatic cmd(input logic [7:0] op);
        tbuf[0] = op;
        xfer(1, 0);
    endtask

    task automatic wren();
        cmd(8'h06);
        m_wel = 1'b1;
    endtask

    task automatic wrdi();
        cmd(8'h04);
        m_wel = 1'b0;
    endtask

    task automatic wrsr(input logic [7:0] v);
        tbuf[0] = 8'h01;
        tbuf[1] = v;
        xfer(2, 0);
        if (m_wel && wp_n) begin
            m_wpen = v[7];
            m_bp   = v[3:2];
        end
        m_wel = 1'b0;
    endtask

    task automatic rdsr_chk(input string req);
        tbuf[0] = 8'h05;
        tbuf[1] = 8'h00;
        xfer(2, 0);
        chk(req, rbuf[1], m_stat());
    endtask

    task automatic mwrite(input logic [15:0] a, input int n, input int tail);
        logic [12:0] ai;
        tbuf[0] = 8'h02;
        tbuf[1] = a[15:8];
        tbuf[2] = a[7:0];
        for (int i = 0; i <= n; i++) tbuf[3 + i] = wdat[i];
        xfer(3 + n, tail);
        ai = a[12:0];
        for (int i = 0; i < n; i++) begin
            if (m_wel && !m_closed(ai)) mdl[ai[SAW-1:0]] = wdat[i];
            ai = ai + 13'd1;
        end
        m_wel = 1'b0;
    endtask

    task automatic mread_chk(input logic [15:0] a, input int n, input string req);
        logic [12:0] ai;
        tbuf[0] = 8'h03;
        tbuf[1] = a[15:8];
        tbuf[2] = a[7:0];
        for (int i = 0; i < n; i++) tbuf[3 + i] = 8'h00;
        xfer(3 + n, 0);
        ai = a[12:0];
        for (int i = 0; i < n; i++) begin
            chk(req, rbuf[3 + i], mdl[ai[SAW-1:0]]);
            ai = ai + 13'd1;
        end
    endtask

    task automatic t_reset();
        chk("R2 idle output", {7'd0, miso}, 8'h00);
        rdsr_chk("R2 reset status");
        chk("R2 reset status literal", rbuf[1], 8'h00);
    endtask

    task automatic t_latch();
        wren();
        rdsr_chk("R3 latch set");
        chk("R3 latch set literal", rbuf[1], 8'h02);
        wrdi();
        rdsr_chk("R3 latch cleared");
    endtask

    task automatic t_status_write();
        wren();
        wrsr(8'hFF);
        rdsr_chk("R1 fixed bits and layout");
        chk("R1 R6 literal", rbuf[1], 8'h8C);
        wrsr(8'h02);
        rdsr_chk("R4 R3 rejected without latch");
        chk("R4 literal", rbuf[1], 8'h8C);
        wren();
        wrsr(8'h08);
        rdsr_chk("R4 accepted with latch");
    endtask

    task automatic t_pin();
        wp_n = 1'b0;
        wren();
        wrsr(8'h00);
        rdsr_chk("R5 R6 pin rejects status write");
        chk("R5 literal", rbuf[1], 8'h08);
        wren();
        wdat[0] = 8'h5A;
        mwrite(16'h0040, 1, 0);
        mread_chk(16'h0040, 1, "R5 pin leaves array open");
        chk("R5 array literal", rbuf[3], 8'h5A);
        wp_n = 1'b1;
    endtask

    task automatic t_status_once();
        wren();
        tbuf[0] = 8'h05;
        tbuf[1] = 8'h00;
        tbuf[2] = 8'h00;
        tbuf[3] = 8'h00;
        xfer(4, 0);
        chk("R7 first reply byte", rbuf[1], 8'h0A);
        chk("R7 second byte zero", rbuf[2], 8'h00);
        chk("R7 third byte zero", rbuf[3], 8'h00);
        wrdi();
    endtask

    task automatic t_burst();
        wren();
        wrsr(8'h00);
        wren();
        wdat[0] = 8'h1E; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h44;
        mwrite(16'h0123, 4, 0);
        mread_chk(16'h0123, 4, "R9 R8 burst");
        chk("R12 MSB first", rbuf[3], 8'h1E);
        rdsr_chk("R6 latch retired after write");
        wdat[0] = 8'h55;
        mwrite(16'h0123, 1, 0);
        mread_chk(16'h0123, 1, "R9 write without latch");
        mread_chk(16'hE123, 2, "R8 top address bits ignored");
    endtask

    task automatic t_quarter();
        wren();
        wrsr(8'h04);
        wren();
        wdat[0] = 8'hA0; wdat[1] = 8'hA1; wdat[2] = 8'hA2; wdat[3] = 8'hA3;
        mwrite(16'h17FE, 4, 0);
        mread_chk(16'h17FE, 2, "R10 below quarter boundary");
        chk("R10 literal", rbuf[4], 8'hA1);
        mread_chk(16'h0000, 2, "R10 quarter bytes dropped");
    endtask

    task automatic t_half_wrap();
        wren();
        wrsr(8'h08);
        wren();
        wdat[0] = 8'hB0; wdat[1] = 8'hB1;
        mwrite(16'h1FFF, 2, 0);
        mread_chk(16'h1FFF, 2, "R10 R9 R8 half with wrap");
        chk("R9 wrap literal", rbuf[4], 8'hB1);
        wren();
        wdat[0] = 8'hC0;
        mwrite(16'h1000, 1, 0);
        mread_chk(16'h1000, 1, "R10 half boundary dropped");
    endtask

    task automatic t_all();
        wren();
        wrsr(8'h0C);
        wren();
        wdat[0] = 8'h77;
        mwrite(16'h0124, 1, 0);
        mread_chk(16'h0124, 1, "R10 all closed");
        rdsr_chk("R6 latch retired with every byte dropped");
    endtask

    task automatic t_abort();
        wren();
        wrsr(8'h00);
        wren();
        wdat[0] = 8'hC5; wdat[1] = 8'hC6;
        mwrite(16'h0050, 1, 5);
        mread_chk(16'h0050, 2, "R11 partial byte discarded");
        chk("R11 literal", rbuf[4], 8'h00);
        rdsr_chk("R6 latch retired after abort");
    endtask

    initial begin
        for (int i = 0; i < (1 << SAW); i++) mdl[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_latch();
        t_status_write();
        t_pin();
        t_status_once();
        t_burst();
        t_quarter();
        t_half_wrap();
        t_all();
        t_abort();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule